// File: doc/BRIEF.md
# Page Write Load Controller

This block sits in front of a behavioural byte-wide nonvolatile array. It gathers a burst of byte writes into a page buffer and then runs a timed programming phase. The first accepted write opens a load and fixes the page from the upper address bits. Later writes to the same page land in the buffer at the offset given by the low six address bits, and each one sets its bit in a per-byte mask. The load closes when no same-page byte has arrived for a configurable number of cycles. The block then stays busy for the programming time. In the last busy cycle it copies only the marked bytes into the array and clears the mask.

Writes enter on a valid/ready port. A write transfers in any cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole programming phase and in the final cycle of an expiring load window. A source that keeps `wr_valid` high waits, and a source that drops it loses the byte. A transferred write whose page differs from the open page is discarded and sets a sticky error flag. The read port is plain: `rd_data` shows the array byte at `rd_addr` one clock later.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset `busy` and `page_error` are low and `wr_ready` is high.
- R2: A write transferred while idle opens a load on page `wr_addr[ADDR_W-1:6]` and stores its data at offset `wr_addr[5:0]`. Same-page writes may use any offset order, and a repeated offset keeps the latest data.
- R3: Call the cycle after a transferred same-page write cycle 1. A further write is still transferred in cycle `LOAD_WIN-1`. If none arrives, `wr_ready` is low in cycle `LOAD_WIN`, that cycle's write is not taken, and `busy` is high from cycle `LOAD_WIN+1`.
- R4: `busy` stays high for exactly `PROG_CYC` cycles with `wr_ready` low throughout. Writes offered during that time change nothing. `wr_ready` returns high when `busy` falls.
- R5: At the end of programming only the offsets loaded in that period change in the array. All other bytes of the page keep their earlier contents.
- R6: A transferred write whose page differs from the open page is not stored. It sets `page_error` and does not restart the load window.
- R7: `page_error` stays high until reset, and later loads still work normally.
- R8: `rd_data` equals the array byte at the `rd_addr` sampled on the previous clock edge.
- R9: One load period holds all 64 offsets of a page, and all of them are committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Write can be taken this cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write byte |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read byte, one cycle after rd_addr |
| busy | output | 1 | Programming phase in progress |
| page_error | output | 1 | Sticky flag: an off-page write was seen |

## Verification
The bench builds the block with an 11-bit address (32 pages), an 8-cycle load window and a 20-cycle programming time. The real-time defaults would need tens of thousands of cycles per window. With these short values the bench can step through the exact closing cycle and the boundary where a byte arrives one cycle before the window ends or one cycle too late. A complete 64-byte page and several partial pages then fit well inside the run.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } plc_state_e;
endpackage

// File: rtl/plc_counter.sv
// Saturating up-counter; done_o flags that LIMIT-1 has been reached.
module plc_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i)   cnt_q <= '0;
    else if (en_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/plc_page_buf.sv
// Page staging buffer: one data byte and one loaded flag per offset.
module plc_page_buf #(
  parameter int PAGE_BYTES = 64,
  parameter int DATA_W     = 8,
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en_i,
  input  logic [OFS_W-1:0]                    wr_ofs_i,
  input  logic [DATA_W-1:0]                   wr_data_i,
  input  logic                                clr_mask_i,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]   bytes_o,
  output logic [PAGE_BYTES-1:0]               mask_o
);
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_en_i && (wr_ofs_i == OFS_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bytes_o[g] <= '0;
        mask_o[g]  <= 1'b0;
      end else begin
        if (hit) bytes_o[g] <= wr_data_i;
        if (clr_mask_i) mask_o[g] <= 1'b0;
        else if (hit)   mask_o[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/plc_mem_array.sv
// Behavioural byte array with masked page commit and a registered read.
module plc_mem_array #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - OFS_W,
  localparam int DEPTH     = 1 << ADDR_W
) (
  input  logic                              clk,
  input  logic                              commit_i,
  input  logic [PG_W-1:0]                   page_i,
  input  logic [PAGE_BYTES-1:0][DATA_W-1:0] bytes_i,
  input  logic [PAGE_BYTES-1:0]             mask_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  output logic [DATA_W-1:0]                 rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (commit_i) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (mask_i[i]) mem[{page_i, OFS_W'(i)}] <= bytes_i[i];
      end
    end
    rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import plc_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  parameter int LOAD_WIN   = 18750,
  parameter int PROG_CYC   = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              page_error
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFS_W;
  localparam int BRW   = $clog2(PROG_CYC + 2) + 1;

  plc_state_e state_q;
  logic [PG_W-1:0] page_q;
  logic gap_done, prog_done;
  logic xfer, in_page, take, off_page, commit;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_bytes;
  logic [PAGE_BYTES-1:0] buf_mask;

  assign busy     = (state_q == ST_PROG);
  assign wr_ready = !busy && !((state_q == ST_LOAD) && gap_done);
  assign xfer     = wr_valid && wr_ready;
  assign in_page  = (wr_addr[ADDR_W-1:OFS_W] == page_q);
  assign take     = xfer && ((state_q == ST_IDLE) || in_page);
  assign off_page = xfer && (state_q == ST_LOAD) && !in_page;
  assign commit   = busy && prog_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      page_q     <= '0;
      page_error <= 1'b0;
    end else begin
      if (off_page) page_error <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (xfer) begin
          state_q <= ST_LOAD;
          page_q  <= wr_addr[ADDR_W-1:OFS_W];
        end
        ST_LOAD: if (gap_done) state_q <= ST_PROG;
        ST_PROG: if (prog_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // inter-byte gap: restarts on every stored byte, only runs while loading
  plc_counter #(.LIMIT(LOAD_WIN)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (take || (state_q != ST_LOAD)),
    .en_i   (state_q == ST_LOAD),
    .done_o (gap_done)
  );

  plc_counter #(.LIMIT(PROG_CYC)) u_prog (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!busy),
    .en_i   (busy),
    .done_o (prog_done)
  );

  plc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (take),
    .wr_ofs_i   (wr_addr[OFS_W-1:0]),
    .wr_data_i  (wr_data),
    .clr_mask_i (commit),
    .bytes_o    (buf_bytes),
    .mask_o     (buf_mask)
  );

  plc_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_arr (
    .clk       (clk),
    .commit_i  (commit),
    .page_i    (page_q),
    .bytes_i   (buf_bytes),
    .mask_i    (buf_mask),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  // checker: length of each busy run
  logic [BRW-1:0] busy_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run_q <= '0;
    else if (busy) busy_run_q <= busy_run_q + 1'b1;
    else           busy_run_q <= '0;
  end

  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> wr_ready);

  p_ready_before_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!wr_ready));

  p_busy_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run_q == BRW'(PROG_CYC)));

  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_error) |-> $past((state_q == ST_LOAD) && wr_valid));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    page_error |=> page_error);
endmodule

// File: tb/sim_page_load_ctrl.sv
module sim_page_load_ctrl;
  localparam int AW = 11;
  localparam int LW = 8;
  localparam int PC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic busy, page_error;

  always #4 clk = ~clk;

  page_load_ctrl #(.ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(64),
                   .LOAD_WIN(LW), .PROG_CYC(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .page_error(page_error)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] model [1 << AW];
  logic [7:0] pend_d [64];
  bit pend_m [64];
  int pend_page;

  typedef struct { int addr; logic [7:0] exp; string req; } rd_item_t;
  rd_item_t q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one-cycle strobe; rdy reports wr_ready in the offered cycle
  task automatic wr(input int a, input logic [7:0] d, output bit rdy);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = AW'(a); wr_data = d;
    #1 rdy = wr_ready;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic stage(input int a, input logic [7:0] d);
    pend_page = a / 64;
    pend_d[a % 64] = d;
    pend_m[a % 64] = 1'b1;
  endtask

  task automatic commit_model();
    for (int i = 0; i < 64; i++) begin
      if (pend_m[i]) model[pend_page * 64 + i] = pend_d[i];
      pend_m[i] = 1'b0;
    end
  endtask

  task automatic rd(input int a, input string req);
    rd_item_t it;
    @(negedge clk);
    rd_addr = AW'(a);
    it.addr = a; it.exp = model[a]; it.req = req;
    q.push_back(it);
  endtask

  task automatic rd_flush();
    repeat (3) @(negedge clk);
  endtask

  // monitor: reply to the address set before this edge
  always begin
    rd_item_t it;
    @(posedge clk);
    if (q.size() != 0) begin
      it = q.pop_front();
      #2 chk(rd_data === it.exp, it.req, int'(rd_data), int'(it.exp));
    end
  end

  // count busy cycles from the current negedge; optionally offer a write in busy cycle 1
  task automatic busy_len(input bit inj, input int ia);
    int n = 0;
    bit rdy_ok = 1;
    while (busy && n < PC + 5) begin
      n++;
      if (!(wr_ready === 1'b0)) rdy_ok = 0;
      if (inj && n == 1) begin wr_valid = 1'b1; wr_addr = AW'(ia); wr_data = 8'h5A; end
      if (inj && n == 2) wr_valid = 1'b0;
      @(negedge clk);
    end
    wr_valid = 1'b0;
    chk(n == PC, "R4 busy length", n, PC);
    chk(rdy_ok, "R4 ready low while busy", rdy_ok, 1);
    chk(wr_ready === 1'b1 && busy === 1'b0, "R4 ready after busy", wr_ready, 1);
  endtask

  // at a negedge that is cycle 'start' after the last stored byte
  task automatic wait_close(input int start, input bit inj, input int ia);
    bit ok = 1;
    for (int c = start; c < LW; c++) begin
      if (!(wr_ready === 1'b1 && busy === 1'b0)) ok = 0;
      @(negedge clk);
    end
    chk(ok, "R3 window open", ok, 1);
    chk(wr_ready === 1'b0 && busy === 1'b0, "R3 ready low in last window cycle", wr_ready, 0);
    @(negedge clk);
    chk(busy === 1'b1, "R3 busy after window", busy, 1);
    busy_len(inj, ia);
  endtask

  task automatic fill_page(input int p);
    bit r;
    for (int i = 0; i < 64; i++) begin
      wr(p * 64 + i, 8'((p * 37 + i * 5 + 1)), r);
      stage(p * 64 + i, 8'((p * 37 + i * 5 + 1)));
    end
    wait_close(1, 0, 0);
    commit_model();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit r;
    for (int i = 0; i < 64; i++) pend_m[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(page_error === 1'b0, "R1 page_error", page_error, 0);
    chk(wr_ready === 1'b1, "R1 wr_ready", wr_ready, 1);

    // R9: full pages
    fill_page(3);
    fill_page(8);
    for (int i = 0; i < 64; i++) rd(3 * 64 + i, "R9 full page 3 / R8 read");
    rd(8 * 64 + 2, "R9 full page 8");
    rd_flush();

    // R2 / R5: partial load, any order, rewrite; R4: dropped write while busy
    wr(3 * 64 + 5, 8'hA1, r);  stage(3 * 64 + 5, 8'hA1);
    wr(3 * 64 + 60, 8'hB2, r); stage(3 * 64 + 60, 8'hB2);
    wr(3 * 64 + 0, 8'hC3, r);  stage(3 * 64 + 0, 8'hC3);
    wr(3 * 64 + 5, 8'hD4, r);  stage(3 * 64 + 5, 8'hD4);
    wait_close(1, 1, 3 * 64 + 9);
    commit_model();
    for (int i = 0; i < 64; i++) rd(3 * 64 + i, "R5 partial commit / R2 / R4 drop");
    rd_flush();

    // R3 boundary: byte in cycle LW-1 taken, byte in cycle LW refused
    wr(3 * 64 + 10, 8'h11, r); stage(3 * 64 + 10, 8'h11);
    repeat (LW - 3) @(negedge clk);
    wr(3 * 64 + 11, 8'h22, r); stage(3 * 64 + 11, 8'h22);
    chk(r == 1'b1, "R3 byte at window edge ready", r, 1);
    repeat (LW - 2) @(negedge clk);
    wr(3 * 64 + 12, 8'h33, r);
    chk(r == 1'b0, "R3 late byte refused", r, 0);
    chk(busy === 1'b1, "R3 busy after late byte", busy, 1);
    busy_len(0, 0);
    commit_model();
    rd(3 * 64 + 10, "R3 first byte");
    rd(3 * 64 + 11, "R3 edge byte");
    rd(3 * 64 + 12, "R3 late byte not stored");
    rd_flush();

    // R6: off-page write discarded, window not restarted
    wr(7 * 64 + 1, 8'h77, r); stage(7 * 64 + 1, 8'h77);
    wr(8 * 64 + 2, 8'h99, r);
    chk(page_error === 1'b1, "R6 page_error set", page_error, 1);
    wait_close(3, 0, 0);
    commit_model();
    rd(7 * 64 + 1, "R6 good byte");
    rd(8 * 64 + 2, "R6 off-page byte not stored");
    rd_flush();

    // R7: flag stays, next load still works
    wr(8 * 64 + 2, 8'h3C, r); stage(8 * 64 + 2, 8'h3C);
    wait_close(1, 0, 0);
    commit_model();
    chk(page_error === 1'b1, "R7 page_error sticky", page_error, 1);
    rd(8 * 64 + 2, "R7 later load");
    rd(8 * 64 + 3, "R7 neighbour kept");
    rd_flush();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule